// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing fields of an instruction into an operand location. A request carries a 3-bit mode, a 3-bit register number, an operand size and the current program counter. The block reads the base register it needs through a register read port. It fetches any extension words through a fetch port, one word at a time, starting at the program counter. It returns one of two results: a register operand selector, or a 32-bit memory address together with the program counter that follows the consumed extension words.

Modes 3 and 4 update an address register. The block applies that change through its own register write port. The caller then performs the operand access itself. Instruction decode and the operand read or write are left to the neighbouring blocks. Requests are accepted only while `busy` is low, and each request finishes with a single-cycle `done`.

Top module: `ea_unit`

## Requirements
- R1: Modes 0 and 1 finish with `res_is_reg`=1 and `res_reg`={mode[0], reg}, where bit 3 set means an address register. They fetch nothing, write no register and return `pc_out` equal to `pc_in`.
- R2: Mode 2 returns the address register An as the address. It writes no register and leaves the PC unchanged.
- R3: Mode 3 returns An as the address and writes An plus the operand size back to An. Size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes.
- R4: Mode 4 subtracts the operand size from An, returns the result as the address and writes it back to An.
- R5: Mode 5 fetches one word at the PC and returns An plus that word sign-extended. The PC advances by 2.
- R6: Mode 6 fetches an index word at the PC. Its fields are: bit 15 (1 = address register, 0 = data register), bits 14:12 (register number), bit 11 (1 = full 32-bit index, 0 = low 16 bits sign-extended) and bits 7:0 (signed displacement). The result is An + index + displacement, and the PC advances by 2.
- R7: Mode 7 with register 0 returns one fetched word, sign-extended. With register 1 it fetches two words and returns the first as the upper half and the second as the lower half, and the PC advances by 4.
- R8: Mode 7 with register 2 returns the address of the first extension word plus that word sign-extended. Register 3 uses the same base, plus an index and displacement decoded as in R6.
- R9: Mode 7 with register 4 (immediate) fetches nothing. The address is the PC, or PC+1 for byte size. The PC advances by 2 for byte or word size and by 4 for long.
- R10: Extension words are requested at consecutive even steps from the PC. Each request holds `ext_req` and `ext_addr` steady until `ext_ack`.
- R11: `done` lasts one cycle. `busy` rises after an accepted `start` and stays high through `done`. A `start` that arrives while busy is ignored.
- R12: Out of reset, and whenever idle, `busy`, `done`, `ext_req` and `wr_en` are low.
- R13: Mode 7 with register 5, 6 or 7 finishes with address 0, no fetch, no register write and an unchanged PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when not busy |
| mode | input | 3 | Addressing mode field |
| reg_num | input | 3 | Register field, or sub-mode when mode is 7 |
| op_size | input | 2 | Operand size code: 0 byte, 1 word, 2 or 3 long |
| pc_in | input | 32 | Program counter at the first extension word |
| busy | output | 1 | Request in progress |
| rd_sel | output | 4 | Register read select, bit 3 set = address register |
| rd_data | input | 32 | Combinational read data for `rd_sel` |
| wr_en | output | 1 | Address register write strobe |
| wr_sel | output | 3 | Address register number to write |
| wr_data | output | 32 | Value written back |
| ext_req | output | 1 | Extension word fetch request |
| ext_addr | output | 32 | Fetch address |
| ext_ack | input | 1 | Fetch completes with `ext_data` |
| ext_data | input | 16 | Fetched extension word |
| done | output | 1 | Result valid for this cycle |
| res_is_reg | output | 1 | Result is a register operand |
| res_reg | output | 4 | Register operand selector |
| res_addr | output | 32 | Memory operand address |
| pc_out | output | 32 | Program counter after the extension words |

## Verification
The assertions assume that `rd_data` is valid in the same cycle as `rd_sel`. They also assume that `ext_ack` is raised only while `ext_req` is high, and that the surroundings never write the registers during a request. The bench meets these assumptions with a behavioural register file. Its fetch responder answers only pending requests, after a programmable wait, and drops its acknowledge after each accepted word. Requests are issued only while `busy` is low. The exception is deliberate `start` pulses during a request, which check that such pulses are ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;
  parameter int AW = 32;
  parameter int EW = 16;
  localparam int EXT_STEP = EW / 8;
  localparam int DISP_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EXT0, ST_EXT1, ST_IDX, ST_CALC, ST_DONE
  } ea_state_t;

  function automatic logic [AW-1:0] sx_word(input logic [EW-1:0] w);
    return {{(AW-EW){w[EW-1]}}, w};
  endfunction

  function automatic logic [AW-1:0] sx_disp(input logic [DISP_W-1:0] d);
    return {{(AW-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return AW'(1);
      2'd1:    return AW'(2);
      default: return AW'(4);
    endcase
  endfunction

  function automatic logic uses_ext(input logic [2:0] m, input logic [2:0] r);
    return (m == 3'd5) || (m == 3'd6) || (m == 3'd7 && r <= 3'd3);
  endfunction

  function automatic logic uses_index(input logic [2:0] m, input logic [2:0] r);
    return (m == 3'd6) || (m == 3'd7 && r == 3'd3);
  endfunction
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  logic [2:0]    mode_q,
  input  logic [2:0]    reg_q,
  input  logic [1:0]    size_q,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc_first,
  input  logic [AW-1:0] pc_cur,
  input  logic [EW-1:0] ext0,
  input  logic [EW-1:0] ext1,
  input  logic [AW-1:0] index,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] pc_next,
  output logic          wb_en,
  output logic [AW-1:0] wb_val
);
  logic [AW-1:0] nbytes;
  logic [AW-1:0] disp8;

  assign nbytes = size_bytes(size_q);
  assign disp8  = sx_disp(ext0[DISP_W-1:0]);

  always_comb begin
    addr    = '0;
    pc_next = pc_cur;
    wb_en   = 1'b0;
    wb_val  = '0;
    case (mode_q)
      3'd2: addr = base;
      3'd3: begin
        addr   = base;
        wb_en  = 1'b1;
        wb_val = base + nbytes;
      end
      3'd4: begin
        addr   = base - nbytes;
        wb_en  = 1'b1;
        wb_val = base - nbytes;
      end
      3'd5: addr = base + sx_word(ext0);
      3'd6: addr = base + index + disp8;
      3'd7: begin
        case (reg_q)
          3'd0: addr = sx_word(ext0);
          3'd1: addr = {ext0, ext1};
          3'd2: addr = pc_first + sx_word(ext0);
          3'd3: addr = pc_first + index + disp8;
          3'd4: begin
            addr    = pc_first + ((size_q == 2'd0) ? AW'(1) : AW'(0));
            pc_next = pc_first + (size_q[1] ? AW'(2*EXT_STEP) : AW'(EXT_STEP));
          end
          default: addr = '0;
        endcase
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    reg_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] pc_i,
  input  logic          ext_ack,
  input  logic [EW-1:0] ext_data,
  input  logic [AW-1:0] rd_data,
  input  logic [AW-1:0] calc_addr,
  input  logic [AW-1:0] calc_pc,
  input  logic          calc_wb,
  output logic          busy,
  output logic          ext_req,
  output logic          wr_en,
  output logic          done,
  output logic [3:0]    rd_sel,
  output logic [2:0]    mode_q,
  output logic [2:0]    reg_q,
  output logic [1:0]    size_q,
  output logic [AW-1:0] pc_first,
  output logic [AW-1:0] pc_q,
  output logic [EW-1:0] ext0_q,
  output logic [EW-1:0] ext1_q,
  output logic [AW-1:0] idx_q,
  output logic [AW-1:0] addr_q,
  output logic          is_reg_q
);
  ea_state_t st;
  logic      accept;
  logic      fetch_fire;

  assign accept     = start && (st == ST_IDLE);
  assign fetch_fire = ext_req && ext_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mode_q   <= '0;
      reg_q    <= '0;
      size_q   <= '0;
      pc_first <= '0;
      pc_q     <= '0;
      ext0_q   <= '0;
      ext1_q   <= '0;
      idx_q    <= '0;
      addr_q   <= '0;
      is_reg_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          mode_q   <= mode_i;
          reg_q    <= reg_i;
          size_q   <= size_i;
          pc_first <= pc_i;
          pc_q     <= pc_i;
          st       <= uses_ext(mode_i, reg_i) ? ST_EXT0 : ST_CALC;
        end
        ST_EXT0: if (fetch_fire) begin
          ext0_q <= ext_data;
          pc_q   <= pc_q + AW'(EXT_STEP);
          if (mode_q == 3'd7 && reg_q == 3'd1) st <= ST_EXT1;
          else if (uses_index(mode_q, reg_q))  st <= ST_IDX;
          else                                 st <= ST_CALC;
        end
        ST_EXT1: if (fetch_fire) begin
          ext1_q <= ext_data;
          pc_q   <= pc_q + AW'(EXT_STEP);
          st     <= ST_CALC;
        end
        ST_IDX: begin
          idx_q <= ext0_q[11] ? rd_data : sx_word(rd_data[EW-1:0]);
          st    <= ST_CALC;
        end
        ST_CALC: begin
          addr_q   <= calc_addr;
          pc_q     <= calc_pc;
          is_reg_q <= (mode_q[2:1] == 2'b00);
          st       <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign ext_req = (st == ST_EXT0) || (st == ST_EXT1);
  assign done    = (st == ST_DONE);
  assign wr_en   = (st == ST_CALC) && calc_wb;
  assign rd_sel  = (st == ST_IDX) ? ext0_q[15:12] : {1'b1, reg_q};
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [2:0]    reg_num,
  input  logic [1:0]    op_size,
  input  logic [AW-1:0] pc_in,
  output logic          busy,
  output logic [3:0]    rd_sel,
  input  logic [AW-1:0] rd_data,
  output logic          wr_en,
  output logic [2:0]    wr_sel,
  output logic [AW-1:0] wr_data,
  output logic          ext_req,
  output logic [AW-1:0] ext_addr,
  input  logic          ext_ack,
  input  logic [EW-1:0] ext_data,
  output logic          done,
  output logic          res_is_reg,
  output logic [3:0]    res_reg,
  output logic [AW-1:0] res_addr,
  output logic [AW-1:0] pc_out
);
  logic [2:0]    mode_q, reg_q;
  logic [1:0]    size_q;
  logic [AW-1:0] pc_first, pc_q, idx_q, addr_q;
  logic [EW-1:0] ext0_q, ext1_q;
  logic          is_reg_q;
  logic [AW-1:0] calc_addr, calc_pc, calc_wbv;
  logic          calc_wb;

  ea_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode_i(mode), .reg_i(reg_num), .size_i(op_size), .pc_i(pc_in),
    .ext_ack(ext_ack), .ext_data(ext_data), .rd_data(rd_data),
    .calc_addr(calc_addr), .calc_pc(calc_pc), .calc_wb(calc_wb),
    .busy(busy), .ext_req(ext_req), .wr_en(wr_en), .done(done), .rd_sel(rd_sel),
    .mode_q(mode_q), .reg_q(reg_q), .size_q(size_q),
    .pc_first(pc_first), .pc_q(pc_q), .ext0_q(ext0_q), .ext1_q(ext1_q),
    .idx_q(idx_q), .addr_q(addr_q), .is_reg_q(is_reg_q)
  );

  ea_calc u_calc (
    .mode_q(mode_q), .reg_q(reg_q), .size_q(size_q), .base(rd_data),
    .pc_first(pc_first), .pc_cur(pc_q), .ext0(ext0_q), .ext1(ext1_q),
    .index(idx_q), .addr(calc_addr), .pc_next(calc_pc),
    .wb_en(calc_wb), .wb_val(calc_wbv)
  );

  assign wr_sel     = reg_q;
  assign wr_data    = calc_wbv;
  assign ext_addr   = pc_q;
  assign res_is_reg = is_reg_q;
  assign res_reg    = {mode_q[0], reg_q};
  assign res_addr   = addr_q;
  assign pc_out     = pc_q;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        wr_en,
  input logic        ext_req,
  input logic        ext_ack,
  input logic [31:0] ext_addr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr))); // R10
  AST_NEXT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (!ext_req || ext_addr == $past(ext_addr) + 32'd2)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R11
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R11
  AST_WB_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ext_req && !wr_en && !done)); // R12
endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .ext_req(ext_req), .ext_ack(ext_ack), .ext_addr(ext_addr)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0, reg_num = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] pc_in = '0;
  logic        busy, wr_en, ext_req, done, res_is_reg;
  logic [3:0]  rd_sel, res_reg;
  logic [2:0]  wr_sel;
  logic [31:0] rd_data, wr_data, ext_addr, res_addr, pc_out;
  logic        ext_ack = 1'b0;
  logic [15:0] ext_data = '0;

  int vectors = 0;
  int miscompares = 0;
  int ext_delay = 0;
  int ack_wait = 0;
  int wr_count = 0;
  bit op_active = 1'b0;
  logic [31:0] regs [0:15];
  logic [15:0] memw [logic [31:0]];
  logic [31:0] fetch_q [$];

  always #5 clk = ~clk;

  ea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_num(reg_num),
    .op_size(op_size), .pc_in(pc_in), .busy(busy), .rd_sel(rd_sel),
    .rd_data(rd_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack),
    .ext_data(ext_data), .done(done), .res_is_reg(res_is_reg),
    .res_reg(res_reg), .res_addr(res_addr), .pc_out(pc_out)
  );

  assign rd_data = regs[rd_sel];

  function automatic logic [15:0] word_at(input logic [31:0] a);
    if (memw.exists(a)) return memw[a];
    return a[15:0] ^ 16'hC3A5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && wr_en) begin
    regs[int'(wr_sel) + 8] <= wr_data;
    wr_count <= wr_count + 1;
  end

  always @(negedge clk) begin
    if (ext_ack) begin
      ext_ack = 1'b0;
      ack_wait = 0;
    end else if (rst_n && ext_req) begin
      if (ack_wait >= ext_delay) begin
        ext_ack = 1'b1;
        ext_data = word_at(ext_addr);
        fetch_q.push_back(ext_addr);
      end else ack_wait++;
    end
    if (rst_n && done && !op_active) chk("R11 unexpected done", 32'(done), 32'd0);
  end

  function automatic logic [31:0] index_of(input logic [15:0] w);
    logic [31:0] v;
    v = regs[{w[15], w[14:12]}];
    return w[11] ? v : 32'($signed(v[15:0]));
  endfunction

  task automatic run_op(input string tag, input logic [2:0] m, input logic [2:0] r,
                        input logic [1:0] s, input logic [31:0] pc,
                        input int dly, input bit poke);
    logic [31:0] e_addr, e_pc, e_wbv, base, w0, w1;
    logic [31:0] e_fetch [$];
    bit e_isreg, e_wb;
    int nb, wr_base, n;
    nb = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    base = regs[int'(r) + 8];
    e_addr = 0; e_pc = pc; e_isreg = 0; e_wb = 0; e_wbv = 0;
    w0 = 32'($signed(word_at(pc)));
    w1 = {16'h0, word_at(pc + 2)};
    case (m)
      3'd0, 3'd1: e_isreg = 1;
      3'd2: e_addr = base;
      3'd3: begin e_addr = base; e_wb = 1; e_wbv = base + nb; end
      3'd4: begin e_addr = base - nb; e_wb = 1; e_wbv = e_addr; end
      3'd5: begin e_fetch.push_back(pc); e_addr = base + w0; end
      3'd6: begin
        e_fetch.push_back(pc);
        e_addr = base + index_of(w0[15:0]) + 32'($signed(w0[7:0]));
      end
      default: case (r)
        3'd0: begin e_fetch.push_back(pc); e_addr = w0; end
        3'd1: begin
          e_fetch.push_back(pc); e_fetch.push_back(pc + 2);
          e_addr = (w0 << 16) | w1;
        end
        3'd2: begin e_fetch.push_back(pc); e_addr = pc + w0; end
        3'd3: begin
          e_fetch.push_back(pc);
          e_addr = pc + index_of(w0[15:0]) + 32'($signed(w0[7:0]));
        end
        3'd4: begin e_addr = pc + ((s == 0) ? 1 : 0); e_pc = pc + ((nb == 4) ? 4 : 2); end
        default: e_addr = 0;
      endcase
    endcase
    e_pc = e_pc + 2 * e_fetch.size();
    ext_delay = dly;
    fetch_q.delete();
    wr_base = wr_count;
    @(negedge clk);
    op_active = 1;
    start = 1; mode = m; reg_num = r; op_size = s; pc_in = pc;
    @(negedge clk);
    start = 0;
    if (poke) begin
      chk({tag, " busy after start"}, 32'(busy), 32'd1);
      start = 1; mode = 3'd7; reg_num = 3'd4; op_size = 2'd0; pc_in = pc + 32'h100;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " is_reg"}, 32'(res_is_reg), 32'(e_isreg));
    if (e_isreg) chk({tag, " reg sel"}, 32'(res_reg), {28'h0, m[0], r});
    else chk({tag, " address"}, res_addr, e_addr);
    chk({tag, " pc"}, pc_out, e_pc);
    chk({tag, " fetch count"}, 32'(fetch_q.size()), 32'(e_fetch.size()));
    foreach (e_fetch[i])
      if (i < fetch_q.size()) chk({tag, " fetch addr"}, fetch_q[i], e_fetch[i]);
    @(negedge clk);
    op_active = 0;
    chk({tag, " writes"}, 32'(wr_count - wr_base), 32'(e_wb));
    if (e_wb) chk({tag, " writeback"}, regs[int'(r) + 8], e_wbv);
    chk({tag, " idle"}, 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0110;
    regs[3]  = 32'h1234_8002;
    regs[10] = 32'h0000_4000;
    regs[12] = 32'hFFFF_FFF0;
    memw[32'h0000_2000] = 16'h0010;
    memw[32'h0000_2100] = 16'hFF00;
    memw[32'h0000_2200] = 16'h30F0;
    memw[32'h0000_2300] = 16'hA810;
    memw[32'h0000_2400] = 16'h8004;
    memw[32'h0000_2500] = 16'h00FE;
    memw[32'h0000_2502] = 16'hDCBA;
    memw[32'h0000_2600] = 16'hFFFC;
    memw[32'h0000_2700] = 16'hC8FF;
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 32'(busy), 32'd0);
    chk("R12 reset done", 32'(done), 32'd0);
    chk("R12 reset req", 32'(ext_req), 32'd0);
    chk("R12 reset wr", 32'(wr_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op("R1 data reg",      3'd0, 3'd5, 2'd1, 32'h1000, 0, 0);
    run_op("R1 addr reg",      3'd1, 3'd3, 2'd2, 32'h1002, 0, 1);
    run_op("R2 indirect",      3'd2, 3'd1, 2'd1, 32'h1004, 0, 0);
    run_op("R3 postinc byte",  3'd3, 3'd2, 2'd0, 32'h1006, 0, 0);
    run_op("R3 postinc word",  3'd3, 3'd2, 2'd1, 32'h1006, 0, 0);
    run_op("R3 postinc long",  3'd3, 3'd2, 2'd2, 32'h1006, 0, 0);
    run_op("R3 postinc code3", 3'd3, 3'd5, 2'd3, 32'h1006, 0, 0);
    run_op("R4 predec byte",   3'd4, 3'd4, 2'd0, 32'h1008, 0, 0);
    run_op("R4 predec long",   3'd4, 3'd4, 2'd2, 32'h1008, 0, 1);
    run_op("R5 disp pos",      3'd5, 3'd2, 2'd1, 32'h2000, 0, 0);
    run_op("R5 disp neg",      3'd5, 3'd6, 2'd1, 32'h2100, 3, 0);
    run_op("R6 data word idx", 3'd6, 3'd2, 2'd1, 32'h2200, 1, 0);
    run_op("R6 addr long idx", 3'd6, 3'd0, 2'd2, 32'h2300, 0, 1);
    run_op("R7 abs short",     3'd7, 3'd0, 2'd1, 32'h2400, 0, 0);
    run_op("R7 abs long",      3'd7, 3'd1, 2'd2, 32'h2500, 2, 0);
    run_op("R8 pc disp",       3'd7, 3'd2, 2'd1, 32'h2600, 0, 0);
    run_op("R8 pc index",      3'd7, 3'd3, 2'd1, 32'h2700, 1, 0);
    run_op("R9 imm byte",      3'd7, 3'd4, 2'd0, 32'h3000, 0, 0);
    run_op("R9 imm word",      3'd7, 3'd4, 2'd1, 32'h3010, 0, 0);
    run_op("R9 imm long",      3'd7, 3'd4, 2'd2, 32'h3020, 0, 1);
    run_op("R10 long fetch",   3'd7, 3'd1, 2'd2, 32'h3100, 4, 1);
    run_op("R13 submode 5",    3'd7, 3'd5, 2'd1, 32'h3200, 0, 0);
    run_op("R13 submode 7",    3'd7, 3'd7, 2'd2, 32'h3300, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule